// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block tracks the coherence state of a set of private cache lines that share a snooping bus with peer caches. Each line is Modified, Exclusive, Shared or Invalid. Local processor reads and writes advance the state of the addressed line, and the block names the bus transaction needed to obtain or upgrade the line. Transactions from other caches seen on the bus are also snooped. Each snoop may demote or invalidate the local copy. When the local copy is the one that must answer, the block raises the matching response: write back dirty data, supply data, or tell the requester that a copy is held.

Lines are selected by a line index, and every line keeps its own state. In one cycle the block accepts one processor request and one snooped transaction. It applies the snoop first and the processor request second, so a request that meets a snoop to the same line acts on the state the snoop leaves behind. All responses are registered and appear one clock after the request. A separate lookup port returns the present state of any line combinationally. Data storage, memory timing and bus arbitration sit outside the block.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line reads Invalid (code 0) on the lookup port, and bus_op, flush, supply and hold are all 0.
- R2: A processor read to an Invalid line issues a bus read (bus_op code 1) and fills the line as Exclusive (code 2) if shared_in is low, or as Shared (code 1) if shared_in is high.
- R3: A processor write to an Invalid line issues read-for-ownership (bus_op code 2) and leaves the line Modified (code 3).
- R4: A processor write to a Shared line issues an upgrade (bus_op code 3) and leaves the line Modified.
- R5: A processor write to an Exclusive line moves it to Modified with bus_op 0.
- R6: A read that hits Modified, Exclusive or Shared, and a write that hits Modified, give bus_op 0 and leave the state unchanged.
- R7: A snooped bus read (snoop_op code 1) to an Exclusive or Shared line moves it to Shared and raises hold. Supply is raised only for Exclusive, and flush stays low.
- R8: A snooped bus read to a Modified line raises flush, supply and hold, and moves the line to Shared.
- R9: A snooped read-for-ownership (code 2) or upgrade (code 3) invalidates the line. Flush is raised only when the line was Modified, and supply and hold stay low.
- R10: A snoop to an Invalid line, or one with snoop_op 0, or with snoop_valid low, changes no state and leaves flush, supply and hold at 0.
- R11: When the snoop and the processor request address the same line in one cycle, the snoop takes effect first and the processor request acts on the resulting state.
- R12: Lines addressed by neither the processor request nor the snoop keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IDX_W | Line addressed by the processor |
| shared_in | input | 1 | A peer cache holds the line (sampled on read fill) |
| snoop_valid | input | 1 | Snooped bus transaction present |
| snoop_op | input | 2 | Snooped kind: 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| snoop_idx | input | IDX_W | Line addressed by the snoop |
| look_idx | input | IDX_W | Line to report on look_state |
| look_state | output | 2 | Present state of line look_idx: 0 I, 1 S, 2 E, 3 M |
| bus_op | output | 2 | Transaction to issue (same codes as snoop_op), registered |
| bus_idx | output | IDX_W | Line of the issued transaction, registered |
| flush | output | 1 | Write back dirty data for the snooped line, registered |
| supply | output | 1 | Provide the line to the requester, registered |
| hold | output | 1 | Shared response to a snooped read, registered |

## Verification
The bench builds the block with four lines instead of the default sixteen. With so few lines, random processor and snoop indices often land on the same line in one cycle, which exercises the snoop-then-request ordering many times. Lines also cycle through all four states many times, so every transition is reached. After each cycle the bench sweeps the lookup port across all four lines, which makes unaddressed-line stability observable on every step.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RD   = 2'b01,
        OP_RDX  = 2'b10,
        OP_UPGR = 2'b11
    } bus_op_e;

    typedef struct packed {
        line_st_e nxt;
        bus_op_e  op;
    } cpu_res_t;

    typedef struct packed {
        line_st_e nxt;
        logic     flush;
        logic     supply;
        logic     hold;
    } snp_res_t;

endpackage

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
    import mesi_pkg::*;
(
    input  line_st_e cur,
    input  logic     req,
    input  logic     wr,
    input  logic     shared_in,
    output cpu_res_t res
);
    always_comb begin
        res.nxt = cur;
        res.op  = OP_NONE;
        if (req) begin
            unique case (cur)
                ST_I: begin
                    if (wr) begin
                        res.nxt = ST_M;
                        res.op  = OP_RDX;
                    end else begin
                        res.nxt = shared_in ? ST_S : ST_E;
                        res.op  = OP_RD;
                    end
                end
                ST_S: begin
                    if (wr) begin
                        res.nxt = ST_M;
                        res.op  = OP_UPGR;
                    end
                end
                ST_E: begin
                    if (wr) begin
                        res.nxt = ST_M;
                    end
                end
                ST_M: begin
                    res.nxt = ST_M;
                end
                default: begin
                    res.nxt = cur;
                end
            endcase
        end
    end
endmodule

// File: rtl/mesi_snoop_fsm.sv
module mesi_snoop_fsm
    import mesi_pkg::*;
(
    input  line_st_e cur,
    input  logic     vld,
    input  bus_op_e  op,
    output snp_res_t res
);
    always_comb begin
        res.nxt    = cur;
        res.flush  = 1'b0;
        res.supply = 1'b0;
        res.hold   = 1'b0;
        if (vld && cur != ST_I) begin
            unique case (op)
                OP_RD: begin
                    res.nxt    = ST_S;
                    res.hold   = 1'b1;
                    res.supply = (cur == ST_E) || (cur == ST_M);
                    res.flush  = (cur == ST_M);
                end
                OP_RDX, OP_UPGR: begin
                    res.nxt   = ST_I;
                    res.flush = (cur == ST_M);
                end
                default: begin
                    res.nxt = cur;
                end
            endcase
        end
    end
endmodule

// File: rtl/mesi_state_store.sv
module mesi_state_store
    import mesi_pkg::*;
#(
    parameter  int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_we,
    input  logic [IDX_W-1:0]       cpu_idx,
    input  line_st_e               cpu_st,
    input  logic                   snp_we,
    input  logic [IDX_W-1:0]       snp_idx,
    input  line_st_e               snp_st,
    output logic [LINES-1:0][1:0]  lines_q
);
    logic [LINES-1:0][1:0] lines_d;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_comb begin
            lines_d[g] = lines_q[g];
            if (cpu_we && cpu_idx == IDX_W'(g)) begin
                lines_d[g] = cpu_st;
            end else if (snp_we && snp_idx == IDX_W'(g)) begin
                lines_d[g] = snp_st;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '0;
        end else begin
            lines_q <= lines_d;
        end
    end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter  int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic             cpu_write,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic             shared_in,
    input  logic             snoop_valid,
    input  logic [1:0]       snoop_op,
    input  logic [IDX_W-1:0] snoop_idx,
    input  logic [IDX_W-1:0] look_idx,
    output logic [1:0]       look_state,
    output logic [1:0]       bus_op,
    output logic [IDX_W-1:0] bus_idx,
    output logic             flush,
    output logic             supply,
    output logic             hold
);
    typedef struct packed {
        bus_op_e          op;
        logic [IDX_W-1:0] idx;
        logic             flush;
        logic             supply;
        logic             hold;
    } resp_t;

    logic [LINES-1:0][1:0] lines_q;
    line_st_e              snp_cur;
    line_st_e              cpu_cur;
    snp_res_t              snp_res;
    cpu_res_t              cpu_res;
    logic                  collide;
    resp_t                 resp_d;
    resp_t                 resp_q;

    assign snp_cur = line_st_e'(lines_q[snoop_idx]);

    mesi_snoop_fsm u_snoop (
        .cur (snp_cur),
        .vld (snoop_valid),
        .op  (bus_op_e'(snoop_op)),
        .res (snp_res)
    );

    assign collide = snoop_valid && (snoop_idx == cpu_idx);
    assign cpu_cur = collide ? snp_res.nxt : line_st_e'(lines_q[cpu_idx]);

    mesi_cpu_fsm u_cpu (
        .cur       (cpu_cur),
        .req       (cpu_valid),
        .wr        (cpu_write),
        .shared_in (shared_in),
        .res       (cpu_res)
    );

    mesi_state_store #(.LINES(LINES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_we  (cpu_valid),
        .cpu_idx (cpu_idx),
        .cpu_st  (cpu_res.nxt),
        .snp_we  (snoop_valid),
        .snp_idx (snoop_idx),
        .snp_st  (snp_res.nxt),
        .lines_q (lines_q)
    );

    always_comb begin
        resp_d        = '0;
        resp_d.op     = cpu_res.op;
        resp_d.idx    = (cpu_res.op != OP_NONE) ? cpu_idx : '0;
        resp_d.flush  = snp_res.flush;
        resp_d.supply = snp_res.supply;
        resp_d.hold   = snp_res.hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign look_state = lines_q[look_idx];
    assign bus_op     = resp_q.op;
    assign bus_idx    = resp_q.idx;
    assign flush      = resp_q.flush;
    assign supply     = resp_q.supply;
    assign hold       = resp_q.hold;
endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk #(
    parameter  int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cpu_valid,
    input logic                  cpu_write,
    input logic                  snoop_valid,
    input logic [1:0]            snoop_op,
    input logic [IDX_W-1:0]      snoop_idx,
    input logic [LINES-1:0][1:0] lines_q,
    input logic [1:0]            bus_op,
    input logic [IDX_W-1:0]      bus_idx,
    input logic                  flush,
    input logic                  supply,
    input logic                  hold
);
    AST_RDX_ENDS_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == 2'b10) |-> (lines_q[bus_idx] == 2'b11 && $past(cpu_valid && cpu_write))); // R3

    AST_UPGR_ENDS_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == 2'b11) |-> (lines_q[bus_idx] == 2'b11 && $past(cpu_valid && cpu_write))); // R4

    AST_OP_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op != 2'b00) |-> $past(cpu_valid)); // R6

    AST_SUPPLY_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        supply |-> hold); // R7

    AST_HOLD_ON_BUSRD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ($past(snoop_valid) && $past(snoop_op) == 2'b01)); // R7

    AST_FLUSH_FROM_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> ($past(lines_q[snoop_idx]) == 2'b11)); // R8

    AST_FLUSH_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> ($past(snoop_valid) && $past(snoop_op) != 2'b00)); // R10
endmodule

bind mesi_snoop_ctrl mesi_snoop_chk #(.LINES(LINES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_valid   (cpu_valid),
    .cpu_write   (cpu_write),
    .snoop_valid (snoop_valid),
    .snoop_op    (snoop_op),
    .snoop_idx   (snoop_idx),
    .lines_q     (lines_q),
    .bus_op      (bus_op),
    .bus_idx     (bus_idx),
    .flush       (flush),
    .supply      (supply),
    .hold        (hold)
);

// File: tb/mesi_snoop_ctrl_tb_top.sv
`timescale 1ns/10ps
module mesi_snoop_ctrl_tb_top;
    localparam int LINES = 4;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cpu_valid = 1'b0, cpu_write = 1'b0, shared_in = 1'b0;
    logic [IDX_W-1:0] cpu_idx = '0, snoop_idx = '0, look_idx = '0, bus_idx;
    logic             snoop_valid = 1'b0;
    logic [1:0]       snoop_op = 2'b00, look_state, bus_op;
    logic             flush, supply, hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int m [LINES];

    always #2 clk = ~clk;

    mesi_snoop_ctrl #(.LINES(LINES)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_idx(cpu_idx), .shared_in(shared_in), .snoop_valid(snoop_valid),
        .snoop_op(snoop_op), .snoop_idx(snoop_idx), .look_idx(look_idx),
        .look_state(look_state), .bus_op(bus_op), .bus_idx(bus_idx),
        .flush(flush), .supply(supply), .hold(hold)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sweep(input string req_hit, input bit cv, input int ci, input bit sv, input int si);
        for (int k = 0; k < LINES; k++) begin
            string t;
            look_idx = IDX_W'(k);
            #0.1;
            t = ((cv && k == ci) || (sv && k == si)) ? req_hit : "R12";
            chk(look_state == 2'(m[k]), t, $sformatf("line%0d state", k), look_state, m[k]);
        end
    endtask

    task automatic step(input bit cv, input bit cw, input int ci, input bit sh,
                        input bit sv, input int so, input int si);
        int e_op = 0, e_idx = 0, e_fl = 0, e_su = 0, e_ho = 0;
        string ctag = "R6";
        string stag = "R10";
        @(negedge clk);
        cpu_valid = cv; cpu_write = cw; cpu_idx = IDX_W'(ci); shared_in = sh;
        snoop_valid = sv; snoop_op = 2'(so); snoop_idx = IDX_W'(si);
        if (sv && so != 0 && m[si] != 0) begin
            if (so == 1) begin
                stag = (m[si] == 3) ? "R8" : "R7";
                e_ho = 1;
                e_su = (m[si] >= 2) ? 1 : 0;
                e_fl = (m[si] == 3) ? 1 : 0;
                m[si] = 1;
            end else begin
                stag = "R9";
                e_fl = (m[si] == 3) ? 1 : 0;
                m[si] = 0;
            end
        end
        if (cv) begin
            case (m[ci])
                0: begin
                    if (cw) begin e_op = 2; m[ci] = 3; ctag = "R3"; end
                    else begin e_op = 1; m[ci] = sh ? 1 : 2; ctag = "R2"; end
                end
                1: if (cw) begin e_op = 3; m[ci] = 3; ctag = "R4"; end
                2: if (cw) begin m[ci] = 3; ctag = "R5"; end
                default: ctag = "R6";
            endcase
            if (e_op != 0) e_idx = ci;
            if (sv && si == ci) ctag = "R11";
        end
        @(posedge clk);
        #1;
        chk(bus_op == 2'(e_op), ctag, "bus_op", bus_op, e_op);
        if (e_op != 0) chk(bus_idx == IDX_W'(e_idx), ctag, "bus_idx", bus_idx, e_idx);
        chk(flush == e_fl[0], stag, "flush", flush, e_fl);
        chk(supply == e_su[0], stag, "supply", supply, e_su);
        chk(hold == e_ho[0], stag, "hold", hold, e_ho);
        sweep(ctag, cv, ci, sv, si);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C0E));
        for (int k = 0; k < LINES; k++) m[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(bus_op == 2'b00, "R1", "bus_op", bus_op, 0);
        chk(flush == 1'b0, "R1", "flush", flush, 0);
        chk(supply == 1'b0, "R1", "supply", supply, 0);
        chk(hold == 1'b0, "R1", "hold", hold, 0);
        sweep("R1", 1'b0, 0, 1'b0, 0);

        // Directed corner cases
        step(1, 0, 0, 0, 0, 0, 0);   // R2 read miss unshared -> E
        step(1, 0, 1, 1, 0, 0, 0);   // R2 read miss shared -> S
        step(1, 0, 0, 0, 0, 0, 0);   // R6 read hit E
        step(1, 1, 0, 0, 0, 0, 0);   // R5 silent E -> M
        step(1, 1, 0, 0, 0, 0, 0);   // R6 write hit M
        step(0, 0, 0, 0, 1, 1, 0);   // R8 snoop read vs M
        step(1, 1, 0, 0, 0, 0, 0);   // R4 write to S -> upgrade
        step(0, 0, 0, 0, 1, 2, 0);   // R9 snoop RdX vs M
        step(0, 0, 0, 0, 1, 3, 1);   // R9 snoop upgrade vs S
        step(1, 1, 2, 0, 0, 0, 0);   // R3 write miss
        step(0, 0, 0, 0, 1, 1, 3);   // R10 snoop vs I
        step(0, 0, 0, 0, 1, 0, 2);   // R10 snoop op none vs M
        step(0, 0, 0, 0, 0, 2, 2);   // R10 snoop_valid low
        step(1, 0, 3, 0, 0, 0, 0);   // R2 -> E
        step(0, 0, 0, 0, 1, 1, 3);   // R7 snoop read vs E
        step(1, 1, 2, 0, 1, 1, 2);   // R11 snoop read M->S then write upgrade
        step(1, 0, 2, 1, 1, 2, 2);   // R11 snoop RdX M->I then read miss

        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(3, 0) != 0, 1'($urandom), int'($urandom_range(LINES - 1, 0)),
                 1'($urandom), 1'($urandom), int'($urandom_range(3, 0)),
                 int'($urandom_range(LINES - 1, 0)));
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule